// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the memory address of an instruction operand for a 16-bit processor that uses segmented memory. From an addressing mode, the current pointer and index register values and the displacement carried by the instruction, it sums a 16-bit offset. It then places that offset inside a segment to give a 20-bit physical address. The segment comes either from a default rule or from an explicit override.

A request is presented for one cycle with `req_valid` high. One cycle later the unit either pulses `addr_valid`, with the offset, physical address and segment code on its outputs, or pulses `addr_err` when the register choice is not allowed for the mode. Register-operand and immediate-operand requests touch no memory and produce neither pulse. The address outputs change only on an accepted memory request and hold their value otherwise. Instruction decoding is done elsewhere: this unit receives the mode and register fields already extracted.

Top module: `seg_ea_gen`

## Requirements
- R1: Mode code 2 (direct) gives an offset equal to the displacement alone.
- R2: With `disp_wide`=0 only `disp[7:0]` is used, sign-extended to 16 bits; with `disp_wide`=1 all 16 bits are used.
- R3: Mode code 3 (register indirect) gives the offset of the one register named by `base_code` (0=BX, 1=BP, 2=SI, 3=DI), and any of the four is legal.
- R4: Mode code 4 (based) adds the displacement to the register in `base_code`; only codes 0 and 1 are legal there.
- R5: Mode code 5 (indexed) adds the displacement to the register in `idx_code`; only codes 2 (SI) and 3 (DI) are legal there.
- R6: Mode code 6 (based indexed) sums the base and index registers, and the displacement has no effect on the offset.
- R7: Mode code 7 (based indexed with displacement) sums base register, index register and displacement.
- R8: The offset wraps modulo 2^16, and the physical address is segment*16 + offset truncated to 20 bits.
- R9: Without override the segment is SS (code 2) when BP is the base or indirect register, and DS (code 3) otherwise; segment codes are ES=0, CS=1, SS=2, DS=3.
- R10: With `ovr_en`=1 the segment is the one named by `ovr_sel`, whatever the mode.
- R11: Mode codes 0 (register) and 1 (immediate) raise neither `addr_valid` nor `addr_err`, and leave the address outputs unchanged.
- R12: Results appear one cycle after the strobe; an illegal register choice pulses `addr_err`, keeps `addr_valid` low and leaves the address outputs unchanged; without a strobe both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| base_code | input | 2 | Base or indirect register code |
| idx_code | input | 2 | Index register code |
| disp | input | 16 | Instruction displacement |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| ea | output | 16 | Effective address offset |
| pa | output | 20 | Physical address |
| seg_used | output | 2 | Segment code applied |
| addr_valid | output | 1 | Address produced (one-cycle pulse) |
| addr_err | output | 1 | Illegal register choice (one-cycle pulse) |

## Verification
Every result of this unit is due exactly one clock edge after the edge that samples `req_valid`: the flags and the address outputs share one register stage. The scoreboard stamps each expected item with the cycle it is due. The monitor compares at the falling edge of that cycle, so strobes on consecutive cycles are checked one by one. In every cycle with no item due, both flags must be low. Held outputs after register, immediate and illegal requests are compared against the last accepted address.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [2:0] {
    AM_REG, AM_IMM, AM_DIRECT, AM_INDIR, AM_BASED, AM_INDEXED, AM_BIDX, AM_BIDX_DISP
  } am_e;
  typedef enum logic [1:0] {RC_BX, RC_BP, RC_SI, RC_DI} rc_e;
  typedef enum logic [1:0] {SG_ES, SG_CS, SG_SS, SG_DS} sg_e;
endpackage

// File: rtl/seg_ea_decode.sv
module seg_ea_decode import seg_ea_pkg::*; (
  input  logic [2:0] mode,
  input  logic [1:0] base_code,
  input  logic [1:0] idx_code,
  output logic       mem_ref,
  output logic       use_disp,
  output logic       use_base,
  output logic       use_idx,
  output logic       illegal,
  output logic       bp_based
);
  logic base_bad, idx_bad;
  assign base_bad = base_code[1];
  assign idx_bad  = !idx_code[1];

  always_comb begin
    mem_ref  = 1'b1;
    use_disp = 1'b0;
    use_base = 1'b0;
    use_idx  = 1'b0;
    illegal  = 1'b0;
    case (am_e'(mode))
      AM_REG, AM_IMM: mem_ref = 1'b0;
      AM_DIRECT:      use_disp = 1'b1;
      AM_INDIR:       use_base = 1'b1;
      AM_BASED: begin
        use_disp = 1'b1; use_base = 1'b1; illegal = base_bad;
      end
      AM_INDEXED: begin
        use_disp = 1'b1; use_idx = 1'b1; illegal = idx_bad;
      end
      AM_BIDX: begin
        use_base = 1'b1; use_idx = 1'b1; illegal = base_bad | idx_bad;
      end
      default: begin
        use_disp = 1'b1; use_base = 1'b1; use_idx = 1'b1;
        illegal = base_bad | idx_bad;
      end
    endcase
  end

  assign bp_based = use_base && (rc_e'(base_code) == RC_BP);
endmodule

// File: rtl/seg_ea_sum.sv
module seg_ea_sum import seg_ea_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [ADDR_W-1:0] reg_bx,
  input  logic [ADDR_W-1:0] reg_bp,
  input  logic [ADDR_W-1:0] reg_si,
  input  logic [ADDR_W-1:0] reg_di,
  input  logic [1:0]        base_code,
  input  logic [1:0]        idx_code,
  input  logic              use_disp,
  input  logic              use_base,
  input  logic              use_idx,
  input  logic [ADDR_W-1:0] disp,
  input  logic              disp_wide,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] disp_ext, base_val, idx_val;
  logic [ADDR_W-1:0] t_disp, t_base, t_idx;

  generate
    if (NARROW_W >= ADDR_W) begin : g_no_ext
      assign disp_ext = disp;
    end else begin : g_ext
      assign disp_ext = disp_wide ? disp
                      : {{(ADDR_W-NARROW_W){disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};
    end
  endgenerate

  always_comb begin
    case (rc_e'(base_code))
      RC_BX:   base_val = reg_bx;
      RC_BP:   base_val = reg_bp;
      RC_SI:   base_val = reg_si;
      default: base_val = reg_di;
    endcase
    case (rc_e'(idx_code))
      RC_DI:   idx_val = reg_di;
      default: idx_val = reg_si;
    endcase
  end

  assign t_disp = use_disp ? disp_ext : '0;
  assign t_base = use_base ? base_val : '0;
  assign t_idx  = use_idx  ? idx_val  : '0;
  assign offset = t_disp + t_base + t_idx;
endmodule

// File: rtl/seg_ea_segsel.sv
module seg_ea_segsel import seg_ea_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [ADDR_W-1:0]           seg_es,
  input  logic [ADDR_W-1:0]           seg_cs,
  input  logic [ADDR_W-1:0]           seg_ss,
  input  logic [ADDR_W-1:0]           seg_ds,
  input  logic                        ovr_en,
  input  logic [1:0]                  ovr_sel,
  input  logic                        bp_based,
  input  logic [ADDR_W-1:0]           offset,
  output logic [1:0]                  seg_code,
  output logic [ADDR_W+SEG_SHIFT-1:0] phys
);
  localparam int PA_W = ADDR_W + SEG_SHIFT;
  logic [3:0][ADDR_W-1:0] seg_tab;
  logic [ADDR_W-1:0]      seg_val;

  assign seg_tab  = {seg_ds, seg_ss, seg_cs, seg_es};
  assign seg_code = ovr_en ? ovr_sel : (bp_based ? SG_SS : SG_DS);
  assign seg_val  = seg_tab[seg_code];
  assign phys     = (PA_W'(seg_val) << SEG_SHIFT) + PA_W'(offset);
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen import seg_ea_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NARROW_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [2:0]                  mode,
  input  logic [1:0]                  base_code,
  input  logic [1:0]                  idx_code,
  input  logic [ADDR_W-1:0]           disp,
  input  logic                        disp_wide,
  input  logic [ADDR_W-1:0]           reg_bx,
  input  logic [ADDR_W-1:0]           reg_bp,
  input  logic [ADDR_W-1:0]           reg_si,
  input  logic [ADDR_W-1:0]           reg_di,
  input  logic [ADDR_W-1:0]           seg_es,
  input  logic [ADDR_W-1:0]           seg_cs,
  input  logic [ADDR_W-1:0]           seg_ss,
  input  logic [ADDR_W-1:0]           seg_ds,
  input  logic                        ovr_en,
  input  logic [1:0]                  ovr_sel,
  output logic [ADDR_W-1:0]           ea,
  output logic [ADDR_W+SEG_SHIFT-1:0] pa,
  output logic [1:0]                  seg_used,
  output logic                        addr_valid,
  output logic                        addr_err
);
  localparam int PA_W = ADDR_W + SEG_SHIFT;

  logic              mem_ref, use_disp, use_base, use_idx, illegal, bp_based;
  logic [ADDR_W-1:0] offset_c;
  logic [PA_W-1:0]   phys_c;
  logic [1:0]        seg_c;
  logic              accept;

  seg_ea_decode u_dec (
    .mode(mode), .base_code(base_code), .idx_code(idx_code),
    .mem_ref(mem_ref), .use_disp(use_disp), .use_base(use_base),
    .use_idx(use_idx), .illegal(illegal), .bp_based(bp_based)
  );

  seg_ea_sum #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_sum (
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .base_code(base_code), .idx_code(idx_code),
    .use_disp(use_disp), .use_base(use_base), .use_idx(use_idx),
    .disp(disp), .disp_wide(disp_wide), .offset(offset_c)
  );

  seg_ea_segsel #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_seg (
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .bp_based(bp_based),
    .offset(offset_c), .seg_code(seg_c), .phys(phys_c)
  );

  assign accept = req_valid && mem_ref && !illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_err   <= 1'b0;
      ea         <= '0;
      pa         <= '0;
      seg_used   <= SG_DS;
    end else begin
      addr_valid <= accept;
      addr_err   <= req_valid && mem_ref && illegal;
      if (accept) begin
        ea       <= offset_c;
        pa       <= phys_c;
        seg_used <= seg_c;
      end
    end
  end
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk #(
  parameter int ADDR_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [2:0]                  mode,
  input logic [1:0]                  base_code,
  input logic [1:0]                  idx_code,
  input logic [ADDR_W-1:0]           seg_es,
  input logic [ADDR_W-1:0]           seg_cs,
  input logic [ADDR_W-1:0]           seg_ss,
  input logic [ADDR_W-1:0]           seg_ds,
  input logic                        ovr_en,
  input logic [1:0]                  ovr_sel,
  input logic [ADDR_W-1:0]           ea,
  input logic [ADDR_W+SEG_SHIFT-1:0] pa,
  input logic [1:0]                  seg_used,
  input logic                        addr_valid,
  input logic                        addr_err
);
  localparam int PA_W = ADDR_W + SEG_SHIFT;
  logic [3:0][ADDR_W-1:0] seg_q;
  always_ff @(posedge clk) seg_q <= {seg_ds, seg_ss, seg_cs, seg_es};

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && addr_err));

  assert_no_strobe_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!addr_valid && !addr_err));

  assert_nonmem_silent_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode <= 3'd1) |=> (!addr_valid && !addr_err && $stable(ea) && $stable(pa)));

  assert_based_bad_base_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd4 && base_code[1]) |=> addr_err);

  assert_indexed_bad_idx_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd5 && !idx_code[1]) |=> addr_err);

  assert_pa_map_R8: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (pa == (PA_W'(seg_q[seg_used]) << SEG_SHIFT) + PA_W'(ea)));

  assert_override_seg_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ovr_en) |=> (!addr_valid || seg_used == $past(ovr_sel)));
endmodule

bind seg_ea_gen seg_ea_chk #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (.*);

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  mode;
  logic [1:0]  base_code, idx_code;
  logic [15:0] disp;
  logic        disp_wide;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_en;
  logic [1:0]  ovr_sel;
  logic [15:0] ea;
  logic [19:0] pa;
  logic [1:0]  seg_used;
  logic        addr_valid, addr_err;

  seg_ea_gen dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          v;
    bit          e;
    logic [15:0] ea;
    logic [19:0] pa;
    logic [1:0]  seg;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          total = 0, bad = 0;
  logic [15:0] last_ea = '0;
  logic [19:0] last_pa = '0;
  logic [1:0]  last_seg = 2'd3;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] regval(input logic [1:0] c);
    case (c)
      2'd0: return reg_bx;
      2'd1: return reg_bp;
      2'd2: return reg_si;
      default: return reg_di;
    endcase
  endfunction

  function automatic logic [15:0] segval(input logic [1:0] c);
    case (c)
      2'd0: return seg_es;
      2'd1: return seg_cs;
      2'd2: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  task automatic drive(input logic [2:0] m, input logic [1:0] b, input logic [1:0] i,
                       input logic [15:0] d, input logic w, input logic oe,
                       input logic [1:0] os, input string tag);
    exp_t        x;
    logic [15:0] dx, sum;
    bit          ub, ui, ud, bad_reg, bpb;
    logic [1:0]  sg;
    dx = w ? d : {{8{d[7]}}, d[7:0]};
    ud = (m == 3'd2) || (m == 3'd4) || (m == 3'd5) || (m == 3'd7);
    ub = (m == 3'd3) || (m == 3'd4) || (m == 3'd6) || (m == 3'd7);
    ui = (m == 3'd5) || (m == 3'd6) || (m == 3'd7);
    bad_reg = ((m >= 3'd4 && m != 3'd5) && b >= 2'd2) || (ui && i < 2'd2);
    sum = (ud ? dx : 16'h0) + (ub ? regval(b) : 16'h0) + (ui ? regval(i) : 16'h0);
    bpb = ub && (b == 2'd1);
    sg  = oe ? os : (bpb ? 2'd2 : 2'd3);
    x.due = cyc + 1;
    x.tag = tag;
    x.v = (m >= 3'd2) && !bad_reg;
    x.e = (m >= 3'd2) && bad_reg;
    if (x.v) begin
      last_ea  = sum;
      last_pa  = ({4'h0, segval(sg)} << 4) + {4'h0, sum};
      last_seg = sg;
    end
    x.ea = last_ea; x.pa = last_pa; x.seg = last_seg;
    q.push_back(x);
    mode = m; base_code = b; idx_code = i; disp = d; disp_wide = w;
    ovr_en = oe; ovr_sel = os; req_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string what, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t x;
        x = q.pop_front();
        chk(addr_valid == x.v, "addr_valid", x.tag, 32'(addr_valid), 32'(x.v));
        chk(addr_err == x.e, "addr_err", x.tag, 32'(addr_err), 32'(x.e));
        chk(ea == x.ea, "ea", x.tag, 32'(ea), 32'(x.ea));
        chk(pa == x.pa, "pa", x.tag, 32'(pa), 32'(x.pa));
        chk(seg_used == x.seg, "seg_used", x.tag, 32'(seg_used), 32'(x.seg));
      end else if (addr_valid || addr_err) begin
        chk(1'b0, "stray flag", "R12", {30'b0, addr_valid, addr_err}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; mode = '0; base_code = '0; idx_code = '0;
    disp = '0; disp_wide = 1'b1; ovr_en = 1'b0; ovr_sel = '0;
    reg_bx = 16'h1234; reg_bp = 16'h8000; reg_si = 16'h00F0; reg_di = 16'hFFFF;
    seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!addr_valid && !addr_err, "reset flags", "R12", {30'b0, addr_valid, addr_err}, 32'h0);
    chk(ea == 16'h0 && pa == 20'h0, "reset address", "R12", 32'(pa), 32'h0);

    drive(3'd2, 2'd0, 2'd2, 16'h3000, 1'b1, 1'b0, 2'd0, "R1");  idle(1);
    drive(3'd2, 2'd0, 2'd2, 16'hAA80, 1'b0, 1'b0, 2'd0, "R2");  idle(1);
    drive(3'd2, 2'd0, 2'd2, 16'h0042, 1'b0, 1'b0, 2'd0, "R2");  idle(1);
    drive(3'd3, 2'd1, 2'd2, 16'h7777, 1'b1, 1'b0, 2'd0, "R3_R9"); idle(1);
    drive(3'd3, 2'd2, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, "R3");  idle(1);
    drive(3'd3, 2'd3, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, "R3");  idle(1);
    drive(3'd4, 2'd0, 2'd2, 16'h0066, 1'b0, 1'b0, 2'd0, "R4");  idle(1);
    drive(3'd4, 2'd1, 2'd2, 16'h00F0, 1'b0, 1'b0, 2'd0, "R4_R9"); idle(1);
    drive(3'd5, 2'd0, 2'd3, 16'h0300, 1'b1, 1'b0, 2'd0, "R5_R8"); idle(1);
    drive(3'd5, 2'd0, 2'd2, 16'h0010, 1'b1, 1'b0, 2'd0, "R5");  idle(1);
    drive(3'd6, 2'd0, 2'd2, 16'h5555, 1'b1, 1'b0, 2'd0, "R6");  idle(1);
    drive(3'd7, 2'd1, 2'd3, 16'h0200, 1'b1, 1'b0, 2'd0, "R7_R9"); idle(1);
    drive(3'd7, 2'd0, 2'd2, 16'h00FE, 1'b0, 1'b0, 2'd0, "R7");  idle(1);
    // illegal register choices
    drive(3'd4, 2'd2, 2'd2, 16'h0001, 1'b1, 1'b0, 2'd0, "R4");  idle(1);
    drive(3'd5, 2'd0, 2'd0, 16'h0001, 1'b1, 1'b0, 2'd0, "R5");  idle(1);
    drive(3'd6, 2'd3, 2'd2, 16'h0000, 1'b1, 1'b0, 2'd0, "R12"); idle(1);
    drive(3'd7, 2'd0, 2'd1, 16'h0000, 1'b1, 1'b0, 2'd0, "R12"); idle(1);
    // non-memory modes
    drive(3'd0, 2'd1, 2'd3, 16'h1111, 1'b1, 1'b0, 2'd0, "R11"); idle(1);
    drive(3'd1, 2'd0, 2'd2, 16'h2222, 1'b1, 1'b1, 2'd1, "R11"); idle(1);
    // overrides
    drive(3'd4, 2'd1, 2'd2, 16'h0004, 1'b1, 1'b1, 2'd0, "R10"); idle(1);
    drive(3'd2, 2'd0, 2'd2, 16'h0100, 1'b1, 1'b1, 2'd1, "R10"); idle(1);
    drive(3'd6, 2'd0, 2'd3, 16'h0000, 1'b1, 1'b1, 2'd2, "R10"); idle(1);
    // physical address wrap
    seg_ds = 16'hFFFF;
    drive(3'd2, 2'd0, 2'd2, 16'h0020, 1'b1, 1'b0, 2'd0, "R8");  idle(1);
    // back-to-back strobes
    drive(3'd3, 2'd0, 2'd2, 16'h0000, 1'b1, 1'b0, 2'd0, "R12");
    drive(3'd5, 2'd2, 2'd1, 16'h0000, 1'b1, 1'b0, 2'd0, "R12");
    drive(3'd0, 2'd0, 2'd2, 16'h0000, 1'b1, 1'b0, 2'd0, "R12");
    drive(3'd7, 2'd1, 2'd2, 16'hFFFF, 1'b1, 1'b0, 2'd0, "R12");
    idle(4);
    chk(q.size() == 0, "queue drained", "R12", 32'(q.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule